// File: doc/BRIEF.md
# Asynchronous SRAM Control Path with Address-Transition Detection

This block is a clock-counted model of the control logic inside a byte-wide static RAM. Three active-low strobes select one of four modes: chip enable, write enable and output enable. The modes are standby, internal read, read and write. The block also watches the address. Any address change, a falling chip enable, or the end of a write restarts an internal read of fixed latency. From that point the output drivers stay released until the word at the new address has been latched.

When a read completes, the word is held in an output register and the array-active flag drops, which models the automatic power reduction during long reads. The held word is driven whenever the read mode is selected, until the next event that re-arms the array.

Writes capture the address and data while the write mode lasts. The word is committed when write enable or chip enable rises, whichever comes first. The storage is a synchronous memory. The upper address bits pick a row and the lower bits pick a column group. The default geometry is kept small for elaboration; 9 row bits and 6 column bits give the full 32K x 8 organisation.

Top module: `sram_atd_ctrl`

## Requirements
- R1: With chip enable high (standby), `bus_drive` is 0 whatever write enable and output enable are. From the edge after standby is sampled, `array_active` is 0, and no write is stored while in standby.
- R2: With chip enable low, write enable high and output enable high (internal read), the read sequence runs (`array_active` goes to 1) but `bus_drive` stays 0.
- R3: With chip enable low, write enable high and output enable low (read), `bus_drive` is 1 and `bus_out` carries the stored word once the read sequence completes.
- R4: With chip enable low and write enable low (write), `bus_drive` is 0 whatever output enable is.
- R5: In the same cycle that the address differs from the value sampled at the previous clock edge, `bus_drive` is 0. It stays 0 until the word at the new address is latched.
- R6: A falling write enable or a rising chip enable ends a read at once (`bus_drive` goes to 0). A new read sequence must complete before data is driven again.
- R7: Address bits [ROW_W+COL_W-1:COL_W] select the row and bits [COL_W-1:0] select the column group. Each address keeps its own 8-bit word.
- R8: `array_active` is 1 from the edge that samples a read trigger until the edge that latches the word, and is 0 afterwards. The latched word stays on `bus_out` while the array is idle.
- R9: Data becomes valid after LAT rising edges (default 3), counting the edge that samples the trigger. A new address within that window restarts the count.
- R10: A write stores the value held on `bus_in` before the first of the write-enable or chip-enable rising edges. Bus changes made together with that rising edge are not stored.
- R11: After an internal read has latched its word, lowering output enable drives the word in the same cycle without a new array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that counts all internal delays |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W+COL_W | Word address |
| bus_in | input | DATA_W | Value present on the data pins (write data) |
| bus_out | output | DATA_W | Value the data pins carry when driven |
| bus_drive | output | 1 | 1 = data pins driven, 0 = high impedance |
| array_active | output | 1 | 1 while the array performs a read access |

## Verification
The assertions check every cycle that the pins are released in standby, in internal read, in write and in any cycle with a fresh address or chip-enable edge. They also check that the array is idle after standby, and that no drive ever occurs sooner than LAT edges after a read trigger. The directed scenarios are needed to show that the correct word appears at each address, how the count restarts partway through, and where a write commits when chip enable rather than write enable ends it. They also show that bus changes at the terminating edge are ignored and that the held word is reused when output enable toggles.

// File: rtl/sram_atd_pkg.sv
package sram_atd_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY  = 2'd0,
        MODE_INT_READ = 2'd1,
        MODE_READ     = 2'd2,
        MODE_WRITE    = 2'd3
    } sram_mode_e;

    typedef struct packed {
        logic ce_fall;
        logic we_rise;
        logic write_end;
    } strobe_evt_t;

    function automatic sram_mode_e decode_mode(input logic ce_n, input logic we_n,
                                               input logic oe_n);
        sram_mode_e m;
        if (ce_n)      m = MODE_STANDBY;
        else if (!we_n) m = MODE_WRITE;
        else if (oe_n) m = MODE_INT_READ;
        else           m = MODE_READ;
        return m;
    endfunction

    function automatic logic is_read_mode(input sram_mode_e m);
        return (m == MODE_INT_READ) || (m == MODE_READ);
    endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_atd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    output sram_mode_e  mode,
    output strobe_evt_t evt
);
    logic       ce_q;
    logic       we_q;
    sram_mode_e mode_q;

    always_comb begin
        mode          = decode_mode(ce_n, we_n, oe_n);
        evt.ce_fall   = ce_q & ~ce_n;
        evt.we_rise   = ~we_q & we_n;
        evt.write_end = (mode_q == MODE_WRITE) && (mode != MODE_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q   <= 1'b1;
            we_q   <= 1'b1;
            mode_q <= MODE_STANDBY;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            mode_q <= mode;
        end
    end
endmodule

// File: rtl/sram_atd_seq.sv
module sram_atd_seq
    import sram_atd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  sram_mode_e        mode,
    input  strobe_evt_t       evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd_en,
    output logic              trigger,
    output logic              busy,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt;
    logic              in_read;

    always_comb begin
        in_read = is_read_mode(mode);
        trigger = in_read & ((addr != addr_q) | evt.ce_fall | evt.we_rise);
        rd_en   = trigger | busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            valid  <= 1'b0;
            dout   <= '0;
        end else begin
            addr_q <= addr;
            if (!in_read) begin
                busy  <= 1'b0;
                valid <= 1'b0;
                cnt   <= '0;
            end else if (trigger) begin
                busy  <= 1'b1;
                valid <= 1'b0;
                cnt   <= CNT_W'(1);
            end else if (busy) begin
                if (cnt == LAST) begin
                    dout  <= rdata;
                    valid <= 1'b1;
                    busy  <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sram_write_capture.sv
module sram_write_capture
    import sram_atd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sram_mode_e        mode,
    input  strobe_evt_t       evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    assign wr_en = evt.write_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (mode == MODE_WRITE) begin
            wr_addr <= addr;
            wr_data <= bus_in;
        end
    end
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ROW_W+COL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [ROW_W+COL_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]       rdata
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;

    logic [DATA_W-1:0] cells [ROWS][COLS];

    logic [ROW_W-1:0] wr_row, rd_row;
    logic [COL_W-1:0] wr_col, rd_col;

    assign wr_row = wr_addr[ADDR_W-1:COL_W];
    assign wr_col = wr_addr[COL_W-1:0];
    assign rd_row = rd_addr[ADDR_W-1:COL_W];
    assign rd_col = rd_addr[COL_W-1:0];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_row][wr_col] <= wr_data;
        if (rd_en) begin
            if (wr_en && (wr_addr == rd_addr))
                rdata <= wr_data;
            else
                rdata <= cells[rd_row][rd_col];
        end
    end
endmodule

// File: rtl/sram_atd_ctrl.sv
module sram_atd_ctrl
    import sram_atd_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 6,
    parameter int DATA_W = 8,
    parameter int LAT    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [DATA_W-1:0]      bus_in,
    output logic [DATA_W-1:0]      bus_out,
    output logic                   bus_drive,
    output logic                   array_active
);
    localparam int ADDR_W = ROW_W + COL_W;

    sram_mode_e        mode;
    strobe_evt_t       evt;
    logic              rd_en, trigger, busy, valid;
    logic [DATA_W-1:0] rdata;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    sram_mode_decode i_decode (
        .clk (clk), .rst (rst),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .mode(mode), .evt (evt)
    );

    sram_atd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) i_seq (
        .clk    (clk),     .rst  (rst),
        .mode   (mode),    .evt  (evt),
        .addr   (addr),    .rdata(rdata),
        .rd_en  (rd_en),   .trigger(trigger),
        .busy   (busy),    .valid(valid),
        .dout   (bus_out)
    );

    sram_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wcap (
        .clk    (clk),     .rst   (rst),
        .mode   (mode),    .evt   (evt),
        .addr   (addr),    .bus_in(bus_in),
        .wr_en  (wr_en),   .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    sram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_array (
        .clk    (clk),
        .wr_en  (wr_en),   .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en  (rd_en),   .rd_addr(addr),    .rdata  (rdata)
    );

    assign bus_drive    = (mode == MODE_READ) & valid & ~trigger;
    assign array_active = busy;
endmodule

// File: rtl/sram_atd_checker.sv
module sram_atd_checker #(
    parameter int ADDR_W = 11,
    parameter int LAT    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              bus_drive,
    input logic              array_active
);
    logic              ce_prev, we_prev;
    logic [ADDR_W-1:0] addr_prev;
    logic [7:0]        since;
    logic              read_evt;

    assign read_evt = !ce_n && we_n && ((addr != addr_prev) || ce_prev || !we_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev   <= 1'b1;
            we_prev   <= 1'b1;
            addr_prev <= '0;
            since     <= '0;
        end else begin
            ce_prev   <= ce_n;
            we_prev   <= we_n;
            addr_prev <= addr;
            if (read_evt)
                since <= 8'd1;
            else if (since != 8'hFF)
                since <= since + 8'd1;
        end
    end

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !bus_drive); // R1
    AST_STANDBY_ARRAY_OFF: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !array_active); // R1
    AST_INT_READ_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n && oe_n) |-> !bus_drive); // R2
    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !we_n) |-> !bus_drive); // R4
    AST_ADDR_CHANGE_HIZ: assert property (@(posedge clk) disable iff (rst)
        read_evt |-> !bus_drive); // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (int'(since) >= LAT)); // R9
endmodule

bind sram_atd_ctrl sram_atd_checker #(.ADDR_W(ADDR_W), .LAT(LAT)) i_atd_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .bus_drive(bus_drive), .array_active(array_active)
);

// File: tb/test_sram_atd_ctrl.sv
module test_sram_atd_ctrl;
    localparam int ROW_W  = 5;
    localparam int COL_W  = 6;
    localparam int DATA_W = 8;
    localparam int LAT    = 3;
    localparam int ADDR_W = ROW_W + COL_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              ce_n, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] bus_in;
    logic [DATA_W-1:0] bus_out;
    logic              bus_drive, array_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sram_atd_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LAT(LAT)) i_sram_atd_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .bus_in(bus_in), .bus_out(bus_out),
        .bus_drive(bus_drive), .array_active(array_active)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic go_standby();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    // R4 / R10: write, terminated by we_n or ce_n rising
    task automatic t_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input bit end_by_ce);
        go_standby();
        addr = a; bus_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        tick(1);
        chk("R4", "drive in write, oe low", int'(bus_drive), 0);
        oe_n = 1'b1;
        tick(1);
        chk("R4", "drive in write, oe high", int'(bus_drive), 0);
        if (end_by_ce) begin
            ce_n = 1'b1; bus_in = ~d;   // R10: change with the terminating edge
            tick(1);
            we_n = 1'b1;
            tick(1);
        end else begin
            we_n = 1'b1; bus_in = ~d;
            tick(1);
            ce_n = 1'b1;
            tick(1);
        end
    endtask

    // R3 / R8 / R9: read from standby
    task automatic t_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input string req);
        go_standby();
        addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        tick(1);
        chk("R8", "array active after trigger", int'(array_active), 1);
        tick(LAT - 2);
        chk("R9", "no drive before latency", int'(bus_drive), 0);
        tick(1);
        chk(req, "drive after latency", int'(bus_drive), 1);
        chk(req, "read data", int'(bus_out), int'(exp));
        chk("R8", "array idle after latch", int'(array_active), 0);
        tick(2);
        chk("R8", "held data still driven", int'(bus_drive), 1);
        chk("R8", "held data value", int'(bus_out), int'(exp));
    endtask

    // R2 / R11: internal read, then output enable
    task automatic t_int_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        go_standby();
        addr = a; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        tick(1);
        chk("R2", "array active in internal read", int'(array_active), 1);
        chk("R2", "no drive in internal read", int'(bus_drive), 0);
        tick(LAT - 1);
        chk("R2", "no drive after latch", int'(bus_drive), 0);
        chk("R2", "array idle after latch", int'(array_active), 0);
        oe_n = 1'b0;
        #1;
        chk("R11", "drive on oe low", int'(bus_drive), 1);
        chk("R11", "data on oe low", int'(bus_out), int'(exp));
        oe_n = 1'b1;
        #1;
        chk("R2", "release on oe high", int'(bus_drive), 0);
    endtask

    // R9: address change part way through restarts the count
    task automatic t_restart(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                             input logic [DATA_W-1:0] expb);
        go_standby();
        addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        tick(LAT - 1);
        addr = b;
        tick(LAT - 1);
        chk("R9", "restarted read not yet valid", int'(bus_drive), 0);
        tick(1);
        chk("R9", "restarted read drive", int'(bus_drive), 1);
        chk("R9", "restarted read data", int'(bus_out), int'(expb));
    endtask

    // R5: address change after valid data
    task automatic t_addr_change(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] expa,
                                 input logic [ADDR_W-1:0] b, input logic [DATA_W-1:0] expb);
        t_read(a, expa, "R3");
        addr = b;
        #1;
        chk("R5", "release on address change", int'(bus_drive), 0);
        tick(LAT - 1);
        chk("R5", "released until new word", int'(bus_drive), 0);
        tick(1);
        chk("R5", "new word driven", int'(bus_drive), 1);
        chk("R5", "new word value", int'(bus_out), int'(expb));
    endtask

    // R6 / R1: read ended by we_n falling and by ce_n rising
    task automatic t_read_end(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        t_read(a, exp, "R3");
        bus_in = exp; we_n = 1'b0;
        #1;
        chk("R6", "release on we fall", int'(bus_drive), 0);
        tick(1);
        we_n = 1'b1;
        tick(LAT - 1);
        chk("R6", "needs new read after we", int'(bus_drive), 0);
        tick(1);
        chk("R6", "driven after new read", int'(bus_drive), 1);
        chk("R6", "data after new read", int'(bus_out), int'(exp));
        ce_n = 1'b1;
        #1;
        chk("R6", "release on ce rise", int'(bus_drive), 0);
        tick(1);
        chk("R1", "array idle in standby", int'(array_active), 0);
        ce_n = 1'b0;
        tick(LAT - 1);
        chk("R6", "needs new read after ce", int'(bus_drive), 0);
        tick(1);
        chk("R6", "driven after ce re-arm", int'(bus_drive), 1);
    endtask

    // R1: standby ignores write and output enables
    task automatic t_standby_ignore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        go_standby();
        addr = a; bus_in = ~exp; we_n = 1'b0; oe_n = 1'b0;
        tick(2);
        chk("R1", "no drive in standby", int'(bus_drive), 0);
        chk("R1", "array idle in standby", int'(array_active), 0);
        we_n = 1'b1;
        tick(1);
        t_read(a, exp, "R1");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; bus_in = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1", "reset drive", int'(bus_drive), 0);
        chk("R1", "reset array flag", int'(array_active), 0);

        t_write(11'h040, 8'h5A, 1'b0);
        t_write(11'h001, 8'hC3, 1'b1);
        t_write(11'h7FF, 8'h96, 1'b0);
        t_write(11'h000, 8'h21, 1'b1);

        t_read(11'h040, 8'h5A, "R10");
        t_read(11'h001, 8'hC3, "R10");
        t_read(11'h7FF, 8'h96, "R3");
        t_read(11'h000, 8'h21, "R7");

        t_int_read(11'h001, 8'hC3);
        t_restart(11'h040, 11'h7FF, 8'h96);
        t_addr_change(11'h000, 8'h21, 11'h040, 8'h5A);
        t_read_end(11'h001, 8'hC3);
        t_standby_ignore(11'h7FF, 8'h96);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule